// File: doc/BRIEF.md
# Boot ROM Shadowing Controller

This block sits between a processor-side memory port and two external word-wide arrays: a slow read-only boot ROM and a faster read-write RAM. When reset is released, it reads every word of the boot image from the ROM and writes each one into a reserved region at the top of the RAM. The processor is held off while this happens. When the copy is finished, the ROM is never enabled again until the next reset. Processor reads of the boot window, which covers the lowest byte addresses, are then served from the RAM copy. All other addresses go straight to RAM at their own word index.

Each memory port follows a fixed wait-state discipline. The block keeps enable, address, write strobe and write data steady for a parameterised number of cycles. It samples read data, or lets the write commit, in the last of those cycles. It then leaves the port idle for one cycle. By default the ROM takes three cycles and the RAM takes one.

The processor port works as a request/acknowledge handshake. Holding the active-low select low is a valid request, and the read/write level and address go with it. `cpu_ready` is a one-cycle acknowledge. The requester applies back-pressure by leaving its request in place until the acknowledge arrives. It must not change the request while it waits, and it must lower the select after the acknowledge unless it wants another access. Until the copy completes, requests are stalled and never dropped.

Top module: `boot_shadow_ctrl`

## Requirements
- R1: After reset, ROM word i (i = 0 to ROM_WORDS-1) is written into RAM word SHADOW_WBASE+i. The default SHADOW_WBASE is RAM_WORDS-ROM_WORDS.
- R2: Every ROM access keeps `rom_en` and `rom_addr` steady for exactly ROM_WAIT cycles. Every RAM access keeps `ram_en`, `ram_we`, `ram_addr` and `ram_wdata` steady for exactly RAM_WAIT cycles. Data is sampled, or committed, in the final cycle, and at least one idle cycle follows each access.
- R3: `copy_done` is low during reset. It rises in the cycle right after the final shadow word is committed and stays high until reset.
- R4: `rom_en` is never high while `copy_done` is high.
- R5: `cpu_ready` stays low while `copy_done` is low. A request that is held through the copy is served after it with correct data.
- R6: While `cpu_sel_n` is 1, no RAM access starts and `cpu_ready` stays low, whatever `cpu_rd_wr_n`, the address and the data show.
- R7: With `cpu_sel_n` at 0, a `cpu_rd_wr_n` of 1 reads and 0 writes. `cpu_addr` is a byte address, and each transfer moves one 32-bit word. The two low address bits are ignored.
- R8: A read whose word index (cpu_addr[9:2]) is below ROM_WORDS returns RAM word SHADOW_WBASE plus that index. It is acknowledged RAM_WAIT+1 cycles after the request is first seen.
- R9: With ALLOW_SHADOW_WR at 0 (the default), a write into the boot window starts no RAM access and is acknowledged 1 cycle after the request. The image stays unchanged.
- R10: Reads and writes with word index ROM_WORDS or above go to RAM word cpu_addr[9:2] unchanged, and writes there take RAM_WAIT+1 cycles.
- R11: `cpu_ready` is high for one cycle at a time. A select still low in the cycle after the acknowledge is a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restarts the copy |
| cpu_sel_n | input | 1 | Active-low request select |
| cpu_rd_wr_n | input | 1 | 1 read, 0 write |
| cpu_addr | input | 10 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle acknowledge |
| copy_done | output | 1 | Shadow image complete |
| rom_en | output | 1 | ROM access enable |
| rom_addr | output | 4 | ROM word address |
| rom_rdata | input | 32 | ROM read word |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 8 | RAM word address |
| ram_wdata | output | 32 | RAM write word |
| ram_rdata | input | 32 | RAM read word |

## Verification
The memory models return a poison word on any cycle other than the last wait cycle, so sampling too early or too late shows up as wrong data instead of passing by chance. A read of the boot window issued during the copy separates stalling from dropping, and separates the RAM image from a direct ROM path. Directed writes into the window and to ordinary addresses separate write protection from pass-through. Seeded random mixes of reads and writes, including writes to the aliased top of RAM and addresses with nonzero low bits, check the address map against a reference memory in the bench.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  typedef enum logic [2:0] {
    CP_RD_REQ,
    CP_RD_WAIT,
    CP_WR_REQ,
    CP_WR_WAIT,
    CP_DONE
  } copy_state_t;

  typedef enum logic [1:0] {
    CU_IDLE,
    CU_BUSY,
    CU_RESP
  } cpu_state_t;

endpackage

// File: rtl/shadow_wait_port.sv
// One memory port with a fixed number of wait cycles per access.
module shadow_wait_port #(
  parameter int WAIT = 1,
  parameter int AW   = 8,
  parameter int DW   = 32,
  localparam int CW  = (WAIT > 1) ? $clog2(WAIT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          idle,
  output logic          fin,
  output logic [DW-1:0] rdata_q,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  logic [CW-1:0] cnt;

  assign idle = !mem_en;
  assign fin  = mem_en && (cnt == CW'(WAIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      cnt       <= '0;
      rdata_q   <= '0;
    end else if (!mem_en) begin
      if (start) begin
        mem_en    <= 1'b1;
        mem_we    <= req_we;
        mem_addr  <= req_addr;
        mem_wdata <= req_wdata;
        cnt       <= '0;
      end
    end else if (fin) begin
      mem_en <= 1'b0;
      mem_we <= 1'b0;
      if (!mem_we) rdata_q <= mem_rdata;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: request fields stay put until the final wait cycle
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !fin) |=> (mem_en && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R2: an idle cycle follows every access
  assert_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !mem_en);

endmodule

// File: rtl/shadow_addr_map.sv
// Boot window decode, redirection into the shadow region, write guard.
module shadow_addr_map #(
  parameter int RAM_AW       = 8,
  parameter int BO           = 2,
  parameter int ROM_WORDS    = 16,
  parameter int SHADOW_WBASE = 240,
  parameter bit ALLOW_WR     = 1'b0
) (
  input  logic [RAM_AW+BO-1:0] cpu_addr,
  input  logic                 cpu_write,
  output logic                 in_window,
  output logic [RAM_AW-1:0]    ram_word,
  output logic                 wr_blocked
);

  localparam logic [RAM_AW-1:0] WIN_END = RAM_AW'(ROM_WORDS);
  localparam logic [RAM_AW-1:0] SBASE   = RAM_AW'(SHADOW_WBASE);

  logic [RAM_AW-1:0] word;

  assign word      = cpu_addr[RAM_AW+BO-1:BO];
  assign in_window = (word < WIN_END);
  assign ram_word  = in_window ? (SBASE + word) : word;

  generate
    if (ALLOW_WR) begin : g_wr_open
      assign wr_blocked = 1'b0;
    end else begin : g_wr_guard
      assign wr_blocked = in_window && cpu_write;
    end
  endgenerate

endmodule

// File: rtl/shadow_copy_seq.sv
// Start-up copy: ROM word -> shadow RAM word, one at a time.
module shadow_copy_seq #(
  parameter int ROM_WORDS    = 16,
  parameter int RAM_AW       = 8,
  parameter int DW           = 32,
  parameter int SHADOW_WBASE = 240,
  localparam int ROM_AW      = $clog2(ROM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rom_idle,
  input  logic              rom_fin,
  input  logic [DW-1:0]     rom_q,
  input  logic              ram_idle,
  input  logic              ram_fin,
  output logic              rom_start,
  output logic [ROM_AW-1:0] rom_req_addr,
  output logic              ram_start,
  output logic [RAM_AW-1:0] ram_req_addr,
  output logic [DW-1:0]     ram_req_wdata,
  output logic              done
);
  import shadow_pkg::*;

  localparam logic [RAM_AW-1:0] SBASE = RAM_AW'(SHADOW_WBASE);
  localparam logic [ROM_AW-1:0] LAST  = ROM_AW'(ROM_WORDS - 1);

  copy_state_t       st;
  logic [ROM_AW-1:0] idx;

  assign rom_start     = (st == CP_RD_REQ);
  assign ram_start     = (st == CP_WR_REQ);
  assign rom_req_addr  = idx;
  assign ram_req_addr  = SBASE + RAM_AW'(idx);
  assign ram_req_wdata = rom_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= CP_RD_REQ;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      unique case (st)
        CP_RD_REQ:  if (rom_idle) st <= CP_RD_WAIT;
        CP_RD_WAIT: if (rom_fin) st <= CP_WR_REQ;
        CP_WR_REQ:  if (ram_idle) st <= CP_WR_WAIT;
        CP_WR_WAIT: if (ram_fin) begin
          if (idx == LAST) begin
            st   <= CP_DONE;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            st  <= CP_RD_REQ;
          end
        end
        default: st <= CP_DONE;
      endcase
    end
  end

  // R3: completion is sticky until reset
  assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R1: no ROM read is launched while a shadow write is outstanding
  assert_one_side_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_start && rom_idle) |-> ram_idle);

endmodule

// File: rtl/boot_shadow_ctrl.sv
module boot_shadow_ctrl #(
  parameter int DW              = 32,
  parameter int ROM_WORDS       = 16,
  parameter int RAM_WORDS       = 256,
  parameter int SHADOW_WBASE    = RAM_WORDS - ROM_WORDS,
  parameter int ROM_WAIT        = 3,
  parameter int RAM_WAIT        = 1,
  parameter bit ALLOW_SHADOW_WR = 1'b0,
  localparam int ROM_AW         = $clog2(ROM_WORDS),
  localparam int RAM_AW         = $clog2(RAM_WORDS),
  localparam int BO             = $clog2(DW / 8),
  localparam int CPU_AW         = RAM_AW + BO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel_n,
  input  logic              cpu_rd_wr_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_ready,
  output logic              copy_done,
  output logic              rom_en,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [DW-1:0]     rom_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DW-1:0]     ram_wdata,
  input  logic [DW-1:0]     ram_rdata
);
  import shadow_pkg::*;

  // copy sequencer <-> ports
  logic              cp_rom_start, cp_ram_start;
  logic [ROM_AW-1:0] cp_rom_addr;
  logic [RAM_AW-1:0] cp_ram_addr;
  logic [DW-1:0]     cp_ram_wdata;
  logic              rom_idle, rom_fin, ram_idle, ram_fin;
  logic [DW-1:0]     rom_q, ram_q;
  logic              rom_we_i;
  logic [DW-1:0]     rom_wdata_i;
  logic              unused_rom_side;

  // CPU path
  cpu_state_t        cu_st;
  logic              win_hit, wr_blocked, cpu_go;
  logic [RAM_AW-1:0] map_word;

  // RAM port request mux
  logic              pr_start, pr_we;
  logic [RAM_AW-1:0] pr_addr;
  logic [DW-1:0]     pr_wdata;

  shadow_copy_seq #(
    .ROM_WORDS(ROM_WORDS), .RAM_AW(RAM_AW), .DW(DW), .SHADOW_WBASE(SHADOW_WBASE)
  ) u_copy (
    .clk(clk), .rst_n(rst_n),
    .rom_idle(rom_idle), .rom_fin(rom_fin), .rom_q(rom_q),
    .ram_idle(ram_idle), .ram_fin(ram_fin),
    .rom_start(cp_rom_start), .rom_req_addr(cp_rom_addr),
    .ram_start(cp_ram_start), .ram_req_addr(cp_ram_addr),
    .ram_req_wdata(cp_ram_wdata), .done(copy_done)
  );

  shadow_wait_port #(.WAIT(ROM_WAIT), .AW(ROM_AW), .DW(DW)) u_rom_port (
    .clk(clk), .rst_n(rst_n),
    .start(cp_rom_start && !copy_done), .req_we(1'b0),
    .req_addr(cp_rom_addr), .req_wdata('0),
    .idle(rom_idle), .fin(rom_fin), .rdata_q(rom_q),
    .mem_en(rom_en), .mem_we(rom_we_i), .mem_addr(rom_addr),
    .mem_wdata(rom_wdata_i), .mem_rdata(rom_rdata)
  );

  assign unused_rom_side = ^{rom_we_i, rom_wdata_i};

  shadow_addr_map #(
    .RAM_AW(RAM_AW), .BO(BO), .ROM_WORDS(ROM_WORDS),
    .SHADOW_WBASE(SHADOW_WBASE), .ALLOW_WR(ALLOW_SHADOW_WR)
  ) u_map (
    .cpu_addr(cpu_addr), .cpu_write(!cpu_rd_wr_n),
    .in_window(win_hit), .ram_word(map_word), .wr_blocked(wr_blocked)
  );

  assign cpu_go = (cu_st == CU_IDLE) && !cpu_sel_n && copy_done && !wr_blocked && ram_idle;

  always_comb begin
    if (copy_done) begin
      pr_start = cpu_go;
      pr_we    = !cpu_rd_wr_n;
      pr_addr  = map_word;
      pr_wdata = cpu_wdata;
    end else begin
      pr_start = cp_ram_start;
      pr_we    = 1'b1;
      pr_addr  = cp_ram_addr;
      pr_wdata = cp_ram_wdata;
    end
  end

  shadow_wait_port #(.WAIT(RAM_WAIT), .AW(RAM_AW), .DW(DW)) u_ram_port (
    .clk(clk), .rst_n(rst_n),
    .start(pr_start), .req_we(pr_we), .req_addr(pr_addr), .req_wdata(pr_wdata),
    .idle(ram_idle), .fin(ram_fin), .rdata_q(ram_q),
    .mem_en(ram_en), .mem_we(ram_we), .mem_addr(ram_addr),
    .mem_wdata(ram_wdata), .mem_rdata(ram_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cu_st <= CU_IDLE;
    end else begin
      unique case (cu_st)
        CU_IDLE: if (!cpu_sel_n && copy_done) begin
          if (wr_blocked)    cu_st <= CU_RESP;
          else if (ram_idle) cu_st <= CU_BUSY;
        end
        CU_BUSY: if (ram_fin) cu_st <= CU_RESP;
        default: cu_st <= CU_IDLE;
      endcase
    end
  end

  assign cpu_ready = (cu_st == CU_RESP);
  assign cpu_rdata = ram_q;

  // R5: no acknowledge before the image is complete
  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_done |-> !cpu_ready);

  // R4: ROM locked out once shadowed
  assert_rom_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |-> !rom_en);

  // R6: deselected cycles launch nothing
  assert_nosel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_done && cu_st == CU_IDLE && cpu_sel_n) |=> (!ram_en && !cpu_ready));

  // R11: acknowledge is a single-cycle pulse
  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  generate
    if (!ALLOW_SHADOW_WR) begin : g_guard_chk
      // R9: window writes never reach the RAM
      assert_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_done && cu_st == CU_IDLE && !cpu_sel_n && !cpu_rd_wr_n && win_hit)
          |=> (!ram_en && cpu_ready));
    end
  endgenerate

endmodule

// File: tb/boot_shadow_ctrl_bench.sv
`timescale 1ns/1ps
module boot_shadow_ctrl_bench;
  localparam int ROM_WORDS = 16;
  localparam int RAM_WORDS = 256;
  localparam int ROM_WAIT  = 3;
  localparam int RAM_WAIT  = 1;
  localparam int SBASE     = RAM_WORDS - ROM_WORDS;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cpu_sel_n, cpu_rd_wr_n;
  logic [9:0]  cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cpu_ready, copy_done;
  logic        rom_en;
  logic [3:0]  rom_addr;
  logic [31:0] rom_rdata;
  logic        ram_en, ram_we;
  logic [7:0]  ram_addr;
  logic [31:0] ram_wdata, ram_rdata;

  boot_shadow_ctrl u_boot_shadow_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_sel_n(cpu_sel_n), .cpu_rd_wr_n(cpu_rd_wr_n),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .copy_done(copy_done),
    .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  int total = 0, bad = 0;
  int edge_cnt = 0, last_commit_edge = -10;
  int rom_cnt = 0, ram_cnt = 0, rom_run = 0, ram_run = 0;
  int stall_viol = 0, rom_late = 0, done_drop = 0;
  logic prev_done = 1'b0;
  logic [31:0] ram_mem [RAM_WORDS];
  logic [31:0] ref_mem [RAM_WORDS];

  function automatic logic [31:0] rom_word(input int i);
    return 32'hB007_0000 + 32'(i) * 32'h0101_0101;
  endfunction

  function automatic int map_word(input logic [9:0] a);
    int w = int'(a[9:2]);
    return (w < ROM_WORDS) ? SBASE + w : w;
  endfunction

  // memory models: data valid only in the last wait cycle
  assign rom_rdata = (rom_en && rom_cnt == ROM_WAIT - 1) ? rom_word(int'(rom_addr)) : 32'hDEAD_BEEF;
  assign ram_rdata = (ram_en && !ram_we && ram_cnt == RAM_WAIT - 1) ? ram_mem[ram_addr] : 32'hDEAD_BEEF;

  always @(posedge clk) begin
    rom_cnt <= rom_en ? rom_cnt + 1 : 0;
    ram_cnt <= ram_en ? ram_cnt + 1 : 0;
    if (ram_en && ram_we && ram_cnt == RAM_WAIT - 1) begin
      ram_mem[ram_addr] <= ram_wdata;
      if (int'(ram_addr) == SBASE + ROM_WORDS - 1 && !copy_done) last_commit_edge <= edge_cnt;
    end
    edge_cnt <= edge_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // port-level monitors
  always @(negedge clk) begin
    if (rst_n) begin
      if (!copy_done && cpu_ready) stall_viol++;
      if (copy_done && rom_en) rom_late++;
      if (prev_done && !copy_done) done_drop++;
      if (copy_done && !prev_done)
        chk("R3 done edge after last commit", 32'(last_commit_edge), 32'(edge_cnt - 1));
      prev_done = copy_done;
      if (rom_en) rom_run++;
      else if (rom_run != 0) begin
        chk("R2 rom enable length", 32'(rom_run), 32'(ROM_WAIT));
        rom_run = 0;
      end
      if (ram_en) ram_run++;
      else if (ram_run != 0) begin
        chk("R2 ram enable length", 32'(ram_run), 32'(RAM_WAIT));
        ram_run = 0;
      end
    end
  end

  task automatic do_access(input logic rd, input logic [9:0] a, input logic [31:0] wd,
                           output logic [31:0] rdo, output int cyc);
    @(negedge clk);
    cpu_sel_n = 1'b0; cpu_rd_wr_n = rd; cpu_addr = a; cpu_wdata = wd; cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 5000);
    rdo = cpu_rdata;
    cpu_sel_n = 1'b1;
  endtask

  initial begin
    #(20 * 180000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc, viol;
    void'($urandom(32'd2024));
    for (int i = 0; i < RAM_WORDS; i++) begin
      ram_mem[i] = 32'h5A00_0000 | 32'(i);
      ref_mem[i] = (i >= SBASE) ? rom_word(i - SBASE) : (32'h5A00_0000 | 32'(i));
    end
    rst_n = 1'b0; cpu_sel_n = 1'b1; cpu_rd_wr_n = 1'b1; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R3 reset copy_done", 32'(copy_done), 32'd0);
    chk("R5 reset cpu_ready", 32'(cpu_ready), 32'd0);
    chk("R4 reset rom_en", 32'(rom_en), 32'd0);
    rst_n = 1'b1;

    // R5: request issued during the copy is stalled, then served
    do_access(1'b1, 10'h014, '0, rd, cyc);
    chk("R5 stalled read data", rd, rom_word(5));
    chk("R5 done before ack", 32'(copy_done), 32'd1);

    // R1: full image in the shadow region
    for (int i = 0; i < ROM_WORDS; i++)
      chk("R1 shadow word", ram_mem[SBASE + i], rom_word(i));

    // R8: window read and its latency
    do_access(1'b1, 10'h008, '0, rd, cyc);
    chk("R8 window read", rd, rom_word(2));
    chk("R8 read latency", 32'(cyc), 32'(RAM_WAIT + 1));

    // R9: window write ignored
    do_access(1'b0, 10'h00C, 32'h1234_5678, rd, cyc);
    chk("R9 blocked write latency", 32'(cyc), 32'd1);
    chk("R9 image intact", ram_mem[SBASE + 3], rom_word(3));
    do_access(1'b1, 10'h00C, '0, rd, cyc);
    chk("R9 readback", rd, rom_word(3));

    // R6: deselected cycles do nothing
    viol = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cpu_sel_n = 1'b1; cpu_rd_wr_n = 1'($urandom); cpu_addr = 10'($urandom);
      cpu_wdata = $urandom;
      @(negedge clk);
      if (ram_en || cpu_ready) viol++;
    end
    chk("R6 no access while deselected", 32'(viol), 32'd0);
    do_access(1'b1, 10'h100, '0, rd, cyc);
    chk("R6 memory untouched", rd, ref_mem[64]);

    // R7: low address bits ignored
    do_access(1'b0, 10'h207, 32'hC0DE_0007, rd, cyc);
    ref_mem[129] = 32'hC0DE_0007;
    do_access(1'b1, 10'h204, '0, rd, cyc);
    chk("R7 aligned read", rd, 32'hC0DE_0007);
    do_access(1'b1, 10'h206, '0, rd, cyc);
    chk("R7 unaligned read", rd, 32'hC0DE_0007);

    // R10: pass-through write lands at its own word
    do_access(1'b0, 10'h320, 32'hFACE_00C8, rd, cyc);
    ref_mem[200] = 32'hFACE_00C8;
    chk("R10 direct word", ram_mem[200], 32'hFACE_00C8);
    chk("R10 write latency", 32'(cyc), 32'(RAM_WAIT + 1));

    // R11: select held low after ack is a new request
    @(negedge clk);
    cpu_sel_n = 1'b0; cpu_rd_wr_n = 1'b1; cpu_addr = 10'h320;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!cpu_ready && cyc < 100);
    @(negedge clk);
    chk("R11 ack pulse width", 32'(cpu_ready), 32'd0);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!cpu_ready && cyc < 100);
    chk("R11 second ack", 32'(cpu_ready), 32'd1);
    chk("R11 second data", cpu_rdata, 32'hFACE_00C8);
    cpu_sel_n = 1'b1;

    // random mix against the reference map (R7, R8, R9, R10)
    for (int n = 0; n < 300; n++) begin
      logic        r = 1'($urandom);
      logic [9:0]  a = 10'($urandom);
      logic [31:0] d = $urandom;
      int          w = map_word(a);
      do_access(r, a, d, rd, cyc);
      if (r) chk("R7 R8 R10 random read", rd, ref_mem[w]);
      else if (int'(a[9:2]) < ROM_WORDS) chk("R9 random window write", 32'(cyc), 32'd1);
      else begin
        ref_mem[w] = d;
        chk("R10 random write", ram_mem[w], d);
      end
    end

    chk("R5 no ack during copy", 32'(stall_viol), 32'd0);
    chk("R4 rom quiet after done", 32'(rom_late), 32'd0);
    chk("R3 done sticky", 32'(done_drop), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule